// File: doc/BRIEF.md
# Sign-Driven Oscillator Phase Aligner

This block sits beside one digital square-wave oscillator in a network of coupled oscillators. Each clock it receives the signed coupling sum computed for that oscillator and turns its sign into a one-bit reference level. A positive sum drives the reference high and a negative sum drives it low. A sum of exactly zero makes the reference copy the oscillator's own present amplitude.

The block finds the rising edges of the reference and of the oscillator amplitude. It counts the clock cycles from a reference rise to the next oscillator rise. When that measurement ends, it adds the count to the oscillator's phase code, wrapping modulo 2^PHASE_W. This pulls the oscillator toward the reference. The phase code is held in the block, and a synchronous reset loads it from an external initial value.

The oscillator waveform itself and the weighted sum are produced elsewhere. This block only derives the reference, measures the edge offset and applies the correction.

Top module: `phase_aligner`

## Requirements
- R1: When `coupling_sum` (two's complement) is greater than zero, `ref_o` is 1 in the same cycle.
- R2: When `coupling_sum` is less than zero, `ref_o` is 0 in the same cycle.
- R3: When `coupling_sum` is exactly zero, `ref_o` equals `osc_amp` in the same cycle.
- R4: A rising edge is a level of 1 in a cycle whose previous cycle had 0. A measurement starts in the cycle where `ref_o` rises and ends in the first later cycle where `osc_amp` rises. The offset is the number of cycles between the two edges. The offset is 0 when both rise in the same cycle.
- R5: At the clock edge that ends a measurement, `phase_o` becomes (previous `phase_o` + offset) mod 2^PHASE_W. With the default PHASE_W = 4 there are 16 codes.
- R6: If `osc_amp` does not rise within 2^PHASE_W - 1 cycles after the reference rise, the measurement is abandoned and `phase_o` stays unchanged.
- R7: `phase_o` changes only at the end of a measurement or on reset.
- R8: While `rst` is high at a clock edge, `phase_o` loads `init_phase` and any measurement is cleared. Levels seen during reset are taken as previous levels, so no edge is reported in the first cycle after reset.
- R9: An `osc_amp` rise with no measurement running is ignored. A second `ref_o` rise during a running measurement neither restarts nor ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_phase | input | PHASE_W | Phase code loaded during reset |
| coupling_sum | input | SUM_W | Signed weighted coupling sum for this oscillator |
| osc_amp | input | 1 | Present amplitude of the oscillator |
| ref_o | output | 1 | Reference level derived from the sum's sign |
| phase_o | output | PHASE_W | Corrected phase code of the oscillator |

## Verification
Every cycle, the assertions check the sign-to-level mapping of the reference. They also check that the phase moves by exactly the measured offset at a commit, that it holds in all other cycles, that an abandoned measurement leaves the phase alone, and that reset loads the initial code. Some behaviour is visible only through the bench's scenarios against its behavioural model. This covers whether the offset really equals the distance between the edges, whether same-cycle edges give a zero offset, and whether stray oscillator rises or repeated reference rises are ignored. It also covers the timeout reached with a stuck oscillator and a reset taken in the middle of a measurement.

// File: rtl/pa_pkg.sv
package pa_pkg;

  typedef enum logic {
    MS_IDLE = 1'b0,
    MS_RUN  = 1'b1
  } meas_state_e;

  // Reference level from the sign of the sum; zero keeps the oscillator level
  function automatic logic ref_level(input logic is_neg, input logic is_zero,
                                     input logic amp);
    logic lvl;
    if (is_zero)      lvl = amp;
    else if (is_neg)  lvl = 1'b0;
    else              lvl = 1'b1;
    return lvl;
  endfunction

  // Rising edge: high now, low one cycle before
  function automatic logic rise_of(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

endpackage

// File: rtl/pa_ref_gen.sv
module pa_ref_gen #(
  parameter int SUM_W = 10
) (
  input  logic signed [SUM_W-1:0] sum_i,
  input  logic                    amp_i,
  output logic                    ref_bit_o
);
  import pa_pkg::*;

  logic sum_neg;
  logic sum_zero;

  assign sum_neg   = sum_i[SUM_W-1];
  assign sum_zero  = (sum_i == '0);
  assign ref_bit_o = ref_level(sum_neg, sum_zero, amp_i);

endmodule

// File: rtl/pa_edge_det.sv
module pa_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  import pa_pkg::*;

  logic prev_q;

  // The level is sampled during reset too, so no edge is reported right after it
  always_ff @(posedge clk) begin
    if (rst) prev_q <= lvl_i;
    else     prev_q <= lvl_i;
  end

  assign rise_o = rise_of(lvl_i, prev_q);

endmodule

// File: rtl/pa_offset_counter.sv
module pa_offset_counter #(
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_rise_i,
  input  logic               osc_rise_i,
  output logic               commit_o,
  output logic               timeout_o,
  output logic               busy_o,
  output logic [PHASE_W-1:0] offset_o,
  output logic [PHASE_W-1:0] cnt_o
);
  import pa_pkg::*;

  localparam logic [PHASE_W-1:0] CNT_LAST = '1;
  localparam logic [PHASE_W-1:0] CNT_ONE  = PHASE_W'(1);

  meas_state_e       state_q;
  logic [PHASE_W-1:0] cnt_q;
  logic              same_cycle;
  logic              run_done;

  assign same_cycle = (state_q == MS_IDLE) && ref_rise_i && osc_rise_i;
  assign run_done   = (state_q == MS_RUN) && osc_rise_i;
  assign timeout_o  = (state_q == MS_RUN) && !osc_rise_i && (cnt_q == CNT_LAST);
  assign commit_o   = same_cycle || run_done;
  assign offset_o   = (state_q == MS_RUN) ? cnt_q : '0;
  assign busy_o     = (state_q == MS_RUN);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MS_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        MS_IDLE: begin
          if (ref_rise_i && !osc_rise_i) begin
            state_q <= MS_RUN;
            cnt_q   <= CNT_ONE;
          end
        end
        MS_RUN: begin
          if (osc_rise_i || timeout_o) begin
            state_q <= MS_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q   <= cnt_q + CNT_ONE;
          end
        end
        default: begin
          state_q <= MS_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/pa_phase_reg.sv
module pa_phase_reg #(
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] init_i,
  input  logic               commit_i,
  input  logic [PHASE_W-1:0] offset_i,
  output logic [PHASE_W-1:0] phase_o
);

  logic [PHASE_W-1:0] phase_q;

  // Addition at PHASE_W bits wraps modulo 2^PHASE_W
  always_ff @(posedge clk) begin
    if (rst)           phase_q <= init_i;
    else if (commit_i) phase_q <= phase_q + offset_i;
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/phase_aligner.sv
module phase_aligner #(
  parameter int PHASE_W = 4,
  parameter int SUM_W   = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PHASE_W-1:0]      init_phase,
  input  logic signed [SUM_W-1:0] coupling_sum,
  input  logic                    osc_amp,
  output logic                    ref_o,
  output logic [PHASE_W-1:0]      phase_o
);

  localparam int N_EDGE = 2;

  logic               ref_w;
  logic [N_EDGE-1:0]  lvl_w;
  logic [N_EDGE-1:0]  rise_w;
  logic               commit_w;
  logic               timeout_w;
  logic               busy_w;
  logic [PHASE_W-1:0] offset_w;
  logic [PHASE_W-1:0] cnt_w;

  pa_ref_gen #(.SUM_W(SUM_W)) u_ref (
    .sum_i     (coupling_sum),
    .amp_i     (osc_amp),
    .ref_bit_o (ref_w)
  );

  // Index 0: reference, index 1: oscillator
  assign lvl_w = {osc_amp, ref_w};

  for (genvar gi = 0; gi < N_EDGE; gi++) begin : g_edge
    pa_edge_det u_edge (
      .clk    (clk),
      .rst    (rst),
      .lvl_i  (lvl_w[gi]),
      .rise_o (rise_w[gi])
    );
  end

  pa_offset_counter #(.PHASE_W(PHASE_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .ref_rise_i (rise_w[0]),
    .osc_rise_i (rise_w[1]),
    .commit_o   (commit_w),
    .timeout_o  (timeout_w),
    .busy_o     (busy_w),
    .offset_o   (offset_w),
    .cnt_o      (cnt_w)
  );

  pa_phase_reg #(.PHASE_W(PHASE_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .init_i   (init_phase),
    .commit_i (commit_w),
    .offset_i (offset_w),
    .phase_o  (phase_o)
  );

  assign ref_o = ref_w;

endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
  parameter int PHASE_W = 4,
  parameter int SUM_W   = 10
) (
  input logic                    clk,
  input logic                    rst,
  input logic [PHASE_W-1:0]      init_phase,
  input logic signed [SUM_W-1:0] coupling_sum,
  input logic                    osc_amp,
  input logic                    ref_o,
  input logic [PHASE_W-1:0]      phase_o,
  input logic                    commit,
  input logic                    timeout,
  input logic                    busy,
  input logic [PHASE_W-1:0]      offset,
  input logic [PHASE_W-1:0]      cnt
);

  AST_REF_POSITIVE: assert property (@(posedge clk) disable iff (rst)
    (coupling_sum > 0) |-> ref_o);                                        // R1

  AST_REF_NEGATIVE: assert property (@(posedge clk) disable iff (rst)
    (coupling_sum < 0) |-> !ref_o);                                       // R2

  AST_REF_ZERO_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (coupling_sum == 0) |-> (ref_o == osc_amp));                          // R3

  AST_BUSY_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt != '0));                                                // R4

  AST_COMMIT_ADDS: assert property (@(posedge clk) disable iff (rst)
    commit |=> (phase_o == PHASE_W'($past(phase_o) + $past(offset))));   // R5

  AST_TIMEOUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    timeout |=> (!busy && $stable(phase_o)));                             // R6

  AST_PHASE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(phase_o));                                        // R7

  AST_RESET_LOADS: assert property (@(posedge clk)
    rst |=> (phase_o == $past(init_phase) && !busy));                     // R8

endmodule

bind phase_aligner pa_checker #(.PHASE_W(PHASE_W), .SUM_W(SUM_W)) u_pa_chk (
  .clk          (clk),
  .rst          (rst),
  .init_phase   (init_phase),
  .coupling_sum (coupling_sum),
  .osc_amp      (osc_amp),
  .ref_o        (ref_o),
  .phase_o      (phase_o),
  .commit       (commit_w),
  .timeout      (timeout_w),
  .busy         (busy_w),
  .offset       (offset_w),
  .cnt          (cnt_w)
);

// File: tb/test_phase_aligner.sv
module test_phase_aligner;
  localparam int PW  = 4;
  localparam int SW  = 10;
  localparam int NPH = 16;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [PW-1:0]        init_phase = PW'(5);
  logic signed [SW-1:0] sum = '0;
  logic                 amp = 1'b0;
  wire                  ref_o;
  wire [PW-1:0]         phase_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  int    m_phase = 0;
  int    m_meas  = 0;
  int    m_el    = 0;
  int    m_pref  = 0;
  int    m_pamp  = 0;
  string m_tag   = "R8";

  phase_aligner #(.PHASE_W(PW), .SUM_W(SW)) i_phase_aligner (
    .clk          (clk),
    .rst          (rst),
    .init_phase   (init_phase),
    .coupling_sum (sum),
    .osc_amp      (amp),
    .ref_o        (ref_o),
    .phase_o      (phase_o)
  );

  always #2 clk = ~clk;

  function automatic int want_ref(input int s, input int a);
    if (s > 0) return 1;
    if (s < 0) return 0;
    return a;
  endfunction

  always @(posedge clk) begin
    int rnow, anow, rr, ar;
    rnow = want_ref(int'(sum), int'(amp));
    anow = int'(amp);
    if (rst) begin
      m_phase = int'(init_phase);
      m_meas  = 0;
      m_el    = 0;
      m_tag   = "R8";
    end else begin
      rr = (rnow == 1 && m_pref == 0) ? 1 : 0;
      ar = (anow == 1 && m_pamp == 0) ? 1 : 0;
      if (m_meas == 0) begin
        if (rr == 1 && ar == 1)      m_tag = "R4 R5 same-cycle";
        else if (rr == 1) begin m_meas = 1; m_el = 1; m_tag = "R4 start"; end
        else if (ar == 1)            m_tag = "R9 stray osc rise";
        else                         m_tag = "R7";
      end else begin
        if (ar == 1) begin
          m_phase = (m_phase + m_el) % NPH;
          m_meas  = 0;
          m_tag   = "R4 R5 commit";
        end else if (m_el == NPH - 1) begin
          m_meas = 0;
          m_tag  = "R6 timeout";
        end else begin
          m_el  = m_el + 1;
          m_tag = (rr == 1) ? "R9 repeat ref rise" : "R7";
        end
      end
    end
    m_pref = rnow;
    m_pamp = anow;
  end

  task automatic step(input int s, input bit a, input bit r);
    int er;
    string rt;
    @(negedge clk);
    checks++;
    if (int'(phase_o) != m_phase) begin
      errors++;
      $display("FAIL %s phase actual %0d expected %0d", m_tag, phase_o, m_phase);
    end
    sum = SW'(s);
    amp = a;
    rst = r;
    #1;
    er = want_ref(s, int'(a));
    rt = (s > 0) ? "R1" : ((s < 0) ? "R2" : "R3");
    checks++;
    if (int'(ref_o) != er) begin
      errors++;
      $display("FAIL %s ref actual %0d expected %0d (sum %0d)", rt, ref_o, er, s);
    end
  endtask

  task automatic run_waves(input int n, input int ref_off, input int osc_off,
                           input int pos_mag, input int neg_mag, input bit zero_mode);
    for (int t = 0; t < n; t++) begin
      bit rw, ow;
      rw = (((t + ref_off) % NPH) < NPH / 2);
      ow = (((t + osc_off) % NPH) < NPH / 2);
      step(zero_mode ? 0 : (rw ? pos_mag : -neg_mag), ow, 1'b0);
    end
  endtask

  initial begin
    // R8: reset loads the initial code
    for (int i = 0; i < 3; i++) step(0, 1'b0, 1'b1);
    // R4 R5: oscillator lags the reference by 3 cycles
    run_waves(64, 0, 13, 37, 20, 1'b0);
    // R1 R2 extremes, edges together: zero offset
    run_waves(48, 4, 4, 511, 512, 1'b0);
    // R1 R2 smallest magnitudes, lag of 9
    run_waves(48, 0, 7, 1, 1, 1'b0);
    // R6: oscillator stuck low, reference keeps rising
    for (int t = 0; t < 40; t++) step(((t % NPH) < 8) ? 5 : -5, 1'b0, 1'b0);
    // R3: zero sum, reference follows oscillator
    run_waves(40, 0, 3, 9, 9, 1'b1);
    // R9: reference held low, oscillator rises are ignored
    run_waves(40, 0, 2, -1, 1, 1'b0);
    // R9: reference rises twice before the oscillator rises
    for (int t = 0; t < 12; t++) step(((t % 4) < 2) ? 3 : -3, 1'b0, 1'b0);
    step(-3, 1'b1, 1'b0);
    step(-3, 1'b0, 1'b0);
    // R8: reset in the middle of a measurement
    run_waves(20, 0, 6, 12, 12, 1'b0);
    init_phase = PW'(11);
    step(12, 1'b0, 1'b1);
    step(12, 1'b0, 1'b1);
    run_waves(40, 5, 0, 12, 12, 1'b0);
    // mixed traffic
    for (int t = 0; t < 400; t++) begin
      int s;
      s = int'($urandom_range(80)) - 40;
      if ((t % 7) == 0) s = 0;
      step(s, bit'($urandom_range(1)), 1'b0);
    end
    step(0, 1'b0, 1'b0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule